// File: doc/BRIEF.md
# High-Page Load Instruction Sequencer

This block is a small execution unit that fetches 8-bit load instructions from a byte-wide memory bus and runs them. It holds a program counter and three byte registers, A, B and C. Each machine cycle it makes exactly one memory access, and the read data comes back in the same cycle as the address. It decodes the opcode and generates the address for each cycle of the instruction.

Four addressing forms are supported. The first uses a full 16-bit immediate address, sent low byte first. The second uses an 8-bit immediate offset into the fixed top page, FF00h to FFFFh. The third uses register C as the offset into that page. The fourth uses the BC pair as the address. The top-page forms never fetch a high address byte, because the upper byte is forced to FFh. This saves one machine cycle in the immediate form only.

No address region is faster than another. The I/O area (FF00h–FF7Fh), the high RAM (FF80h–FFFEh) and the last register (FFFFh) all cost the same single cycle per access. B and C have no load instruction here, so they are preset through a side input. A position counter shows which cycle of the current instruction is running.

Top module: `hpage_ldseq`

## Requirements
- R1: While rst_n is low, pc_q is PC_RESET (0000h), a_q is 00h, m_idx is 0 and mem_we is 0.
- R2: Opcode FAh takes 4 cycles. It reads the opcode at pc, the low address byte at pc+1 and the high byte at pc+2, then loads A from {high,low}. pc then advances by 3.
- R3: Opcode EAh takes 4 cycles with the same fetch order as FAh. In the fourth cycle it writes A to {high,low}, with mem_we high for exactly that one cycle.
- R4: Opcodes F0h (load) and E0h (store) take 3 cycles. The data access goes to FF00h plus the byte at pc+1, and pc advances by 2.
- R5: Opcodes F2h (load) and E2h (store) take 2 cycles. The data access goes to FF00h plus C, B has no effect, and pc advances by 1.
- R6: Opcodes 0Ah (load) and 02h (store) take 2 cycles. The data access goes to address {B,C}, and pc advances by 1.
- R7: mem_we is high only in the last cycle of a store (EAh, E0h, E2h, 02h). It is never high in an opcode fetch cycle or during any load.
- R8: Any other opcode runs as a 1-cycle no-operation. pc advances by 1, A is unchanged and nothing is written.
- R9: instr_done is high for exactly the last cycle of every instruction. m_idx is 0 in the opcode cycle and counts up by one each cycle until instr_done.
- R10: A top-page data access costs the same cycle count at every offset. Offsets 00h, 7Fh, 80h, FEh and FFh all give 3 cycles for the immediate form.
- R11: While bc_load is high, B takes bc_value[15:8] and C takes bc_value[7:0] at each clock edge. This also applies during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bc_load | input | 1 | Preset strobe for B and C |
| bc_value | input | 16 | Preset value, {B,C} |
| mem_rdata | input | 8 | Read data, valid in the cycle the address is presented |
| mem_addr | output | 16 | Address of this cycle's access |
| mem_wdata | output | 8 | Write data (register A) |
| mem_we | output | 1 | Write enable |
| instr_done | output | 1 | High in the last cycle of an instruction |
| m_idx | output | 2 | Cycle position inside the current instruction |
| pc_q | output | 16 | Program counter |
| a_q | output | 8 | Register A |
| b_q | output | 8 | Register B |
| c_q | output | 8 | Register C |

## Verification
Some rules hold on every cycle, and the assertions check them there. The write enable never appears in an opcode cycle, only appears together with instr_done, and lasts one cycle. The opcode fetch address always equals the program counter. The position counter steps by one and wraps to zero after instr_done. A changes only after an instruction ends. Other results depend on a chosen opcode and operands, so only the bench scenarios can show them. These are the exact cycle count of each form, the address of the data access, the effect of B on the C form, the value that lands in A or memory, the program counter step, equal cost across the top page regions, and the no-operation path.

// File: rtl/hpage_ldseq.sv
module hpage_ldseq #(
  parameter logic [15:0] PC_RESET = 16'h0000,
  parameter logic [7:0]  TOP_PAGE = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bc_load,
  input  logic [15:0] bc_value,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        instr_done,
  output logic [1:0]  m_idx,
  output logic [15:0] pc_q,
  output logic [7:0]  a_q,
  output logic [7:0]  b_q,
  output logic [7:0]  c_q
);

  localparam logic [7:0] OP_LD_ABS  = 8'hFA;
  localparam logic [7:0] OP_ST_ABS  = 8'hEA;
  localparam logic [7:0] OP_LD_PGI  = 8'hF0;
  localparam logic [7:0] OP_ST_PGI  = 8'hE0;
  localparam logic [7:0] OP_LD_PGC  = 8'hF2;
  localparam logic [7:0] OP_ST_PGC  = 8'hE2;
  localparam logic [7:0] OP_LD_PAIR = 8'h0A;
  localparam logic [7:0] OP_ST_PAIR = 8'h02;

  typedef enum logic [1:0] {S_OP, S_LO, S_HI, S_MEM} st_t;
  typedef enum logic [2:0] {K_NONE, K_ABS, K_PGI, K_PGC, K_PAIR} kind_t;

  st_t        st, st_nx;
  logic [7:0] op_q, lo_q, hi_q;
  kind_t      k_raw, k_op;
  logic       store_op;

  function automatic kind_t kind_of(input logic [7:0] o);
    case (o)
      OP_LD_ABS,  OP_ST_ABS:  kind_of = K_ABS;
      OP_LD_PGI,  OP_ST_PGI:  kind_of = K_PGI;
      OP_LD_PGC,  OP_ST_PGC:  kind_of = K_PGC;
      OP_LD_PAIR, OP_ST_PAIR: kind_of = K_PAIR;
      default:                kind_of = K_NONE;
    endcase
  endfunction

  assign k_raw     = kind_of(mem_rdata);
  assign k_op      = kind_of(op_q);
  assign store_op  = (op_q == OP_ST_ABS) || (op_q == OP_ST_PGI) ||
                     (op_q == OP_ST_PGC) || (op_q == OP_ST_PAIR);
  assign mem_wdata = a_q;

  always_comb begin
    st_nx      = st;
    mem_addr   = pc_q;
    mem_we     = 1'b0;
    instr_done = 1'b0;
    case (st)
      S_OP: begin
        case (k_raw)
          K_ABS, K_PGI:  st_nx = S_LO;
          K_PGC, K_PAIR: st_nx = S_MEM;
          default: begin
            st_nx      = S_OP;
            instr_done = 1'b1;
          end
        endcase
      end
      S_LO:  st_nx = (k_op == K_ABS) ? S_HI : S_MEM;
      S_HI:  st_nx = S_MEM;
      S_MEM: begin
        case (k_op)
          K_ABS:   mem_addr = {hi_q, lo_q};
          K_PGI:   mem_addr = {TOP_PAGE, lo_q};
          K_PGC:   mem_addr = {TOP_PAGE, c_q};
          default: mem_addr = {b_q, c_q};
        endcase
        mem_we     = store_op;
        instr_done = 1'b1;
        st_nx      = S_OP;
      end
      default: st_nx = S_OP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_OP;
      pc_q  <= PC_RESET;
      a_q   <= 8'h00;
      op_q  <= 8'h00;
      lo_q  <= 8'h00;
      hi_q  <= 8'h00;
      m_idx <= 2'd0;
    end else begin
      st    <= st_nx;
      m_idx <= instr_done ? 2'd0 : m_idx + 2'd1;
      case (st)
        S_OP: begin
          op_q <= mem_rdata;
          pc_q <= pc_q + 16'd1;
        end
        S_LO: begin
          lo_q <= mem_rdata;
          pc_q <= pc_q + 16'd1;
        end
        S_HI: begin
          hi_q <= mem_rdata;
          pc_q <= pc_q + 16'd1;
        end
        default: if (!store_op) a_q <= mem_rdata;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (bc_load) begin
      b_q <= bc_value[15:8];
      c_q <= bc_value[7:0];
    end else if (!rst_n) begin
      b_q <= 8'h00;
      c_q <= 8'h00;
    end
  end

endmodule

// File: rtl/hpage_ldseq_chk.sv
module hpage_ldseq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_we,
  input logic        instr_done,
  input logic [1:0]  m_idx,
  input logic [15:0] mem_addr,
  input logic [15:0] pc_q,
  input logic [7:0]  a_q
);

  AST_WE_NOT_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (m_idx != 2'd0)); // R7
  AST_WE_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> instr_done); // R7
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R3
  AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (m_idx == 2'd0) |-> (mem_addr == pc_q)); // R2
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_done |=> (m_idx == $past(m_idx) + 2'd1)); // R9
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> (m_idx == 2'd0)); // R9
  AST_A_HELD_MIDWAY: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_done |=> $stable(a_q)); // R8

endmodule

bind hpage_ldseq hpage_ldseq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .instr_done(instr_done),
  .m_idx(m_idx), .mem_addr(mem_addr), .pc_q(pc_q), .a_q(a_q)
);

// File: tb/hpage_ldseq_tb.sv
module hpage_ldseq_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 12;
  // {opcode, byte1, byte2, bc, cycles, data address}
  localparam logic [63:0] VEC [0:NV-1] = '{
    {8'hFA, 8'h34, 8'h12, 16'h0000, 8'd4, 16'h1234},
    {8'hEA, 8'h78, 8'h56, 16'h0000, 8'd4, 16'h5678},
    {8'hF0, 8'h00, 8'h00, 16'h0000, 8'd3, 16'hFF00},
    {8'hE0, 8'h7F, 8'h00, 16'h0000, 8'd3, 16'hFF7F},
    {8'hF0, 8'h80, 8'h00, 16'h0000, 8'd3, 16'hFF80},
    {8'hE0, 8'hFE, 8'h00, 16'h0000, 8'd3, 16'hFFFE},
    {8'hF0, 8'hFF, 8'h00, 16'h0000, 8'd3, 16'hFFFF},
    {8'hF2, 8'h00, 8'h00, 16'h0010, 8'd2, 16'hFF10},
    {8'hE2, 8'h00, 8'h00, 16'hABFE, 8'd2, 16'hFFFE},
    {8'h0A, 8'h00, 8'h00, 16'h4321, 8'd2, 16'h4321},
    {8'h02, 8'h00, 8'h00, 16'h9876, 8'd2, 16'h9876},
    {8'hF2, 8'h00, 8'h00, 16'h5500, 8'd2, 16'hFF00}
  };

  logic clk = 1'b0, rst_n = 1'b0, bc_load = 1'b0;
  logic [15:0] bc_value = 16'h0;
  logic [7:0]  mem_rdata, mem_wdata, a_q, b_q, c_q;
  logic [15:0] mem_addr, pc_q;
  logic        mem_we, instr_done;
  logic [1:0]  m_idx;
  logic [7:0]  mem [0:65535];
  int n_chk = 0, n_bad = 0, cyc = 0;
  int r_cyc, r_we, r_idxbad;
  logic [15:0] r_addr, r_fetch;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  hpage_ldseq dut_i (.clk(clk), .rst_n(rst_n), .bc_load(bc_load), .bc_value(bc_value),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .instr_done(instr_done), .m_idx(m_idx), .pc_q(pc_q), .a_q(a_q), .b_q(b_q), .c_q(c_q));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] bc);
    @(negedge clk);
    rst_n = 1'b0; bc_load = 1'b1; bc_value = bc;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; bc_load = 1'b0;
  endtask

  task automatic run_instr();
    r_cyc = 0; r_we = 0; r_idxbad = 0; r_fetch = mem_addr;
    for (int k = 0; k < 8; k++) begin
      r_cyc++;
      if (m_idx != 2'(k)) r_idxbad++;
      r_addr = mem_addr;
      if (mem_we) r_we++;
      if (instr_done) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    do_reset(16'h0000);
    check("R1 pc", 32'(pc_q), 32'h0);
    // reset state observed with reset held
    @(negedge clk); rst_n = 1'b0; bc_load = 1'b1; bc_value = 16'hC3D4;
    @(posedge clk); #1;
    check("R1 pc in reset", 32'(pc_q), 32'h0);
    check("R1 a in reset", 32'(a_q), 32'h0);
    check("R1 m_idx in reset", 32'(m_idx), 32'h0);
    check("R1 we in reset", 32'(mem_we), 32'h0);
    check("R11 b preset", 32'(b_q), 32'hC3);
    check("R11 c preset", 32'(c_q), 32'hD4);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] op, aval, dval; logic [15:0] tgt; int ncyc, len; logic st;
      op = VEC[i][63:56]; ncyc = int'(VEC[i][23:16]); tgt = VEC[i][15:0];
      st = (op == 8'hEA) || (op == 8'hE0) || (op == 8'hE2) || (op == 8'h02);
      len = (ncyc == 4) ? 3 : (ncyc == 3) ? 2 : 1;
      aval = 8'hA5 ^ 8'(i); dval = 8'h3C + 8'(i * 7);
      mem[16'h8000] = aval;
      mem[0] = 8'hFA; mem[1] = 8'h00; mem[2] = 8'h80;
      mem[3] = op; mem[4] = VEC[i][55:48]; mem[5] = VEC[i][47:40]; mem[6] = 8'h00;
      mem[tgt] = dval;
      do_reset(VEC[i][39:24]);
      run_instr();
      check("R2 preload A", 32'(a_q), 32'(aval));
      run_instr();
      check($sformatf("R9 R10 cycles v%0d", i), r_cyc, ncyc);
      check($sformatf("R9 m_idx seq v%0d", i), r_idxbad, 0);
      check($sformatf("R2 fetch addr v%0d", i), 32'(r_fetch), 32'h3);
      check($sformatf("R4 R5 R6 data addr v%0d", i), 32'(r_addr), 32'(tgt));
      check($sformatf("R7 we count v%0d", i), r_we, st ? 1 : 0);
      check($sformatf("R2 pc step v%0d", i), 32'(pc_q), 32'(3 + len));
      if (st) check($sformatf("R3 stored v%0d", i), 32'(mem[tgt]), 32'(aval));
      else    check($sformatf("R2 loaded v%0d", i), 32'(a_q), 32'(dval));
    end

    // undefined opcode as a 1-cycle no-operation
    mem[16'h8000] = 8'h66;
    mem[0] = 8'hFA; mem[1] = 8'h00; mem[2] = 8'h80; mem[3] = 8'h76; mem[4] = 8'h00;
    do_reset(16'h0000);
    run_instr();
    run_instr();
    check("R8 nop cycles", r_cyc, 1);
    check("R8 nop we", r_we, 0);
    check("R8 nop pc", 32'(pc_q), 32'h4);
    check("R8 nop A", 32'(a_q), 32'h66);
    check("R8 nop addr", 32'(r_addr), 32'h3);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule